// File: doc/BRIEF.md
# Multi-Word Memory Micro-Op Sequencer

This block sits between instruction decode and a register file that offers two read ports and a single write port. Any memory instruction that would need more than one register write, or more than one register read in the same stage, is broken here into a sequence of single-register micro-operations. One micro-op leaves the block per cycle, and each one carries the register it touches, its byte offset from the base address, and flags that tell later stages whether it writes the register file, whether it is the base writeback, and in which stage its result becomes available.

Three sequence shapes are supported. A multi-word transfer moves a run of ascending registers, one word each; a single load or store is this shape with a count of one, and a double-word transfer is a count of two. A paired register move writes the even register of a pair and then the odd one. A store whose address offset is a register reads the base in one micro-op and the store data in a second. A base-register writeback, when requested, always takes its own micro-op after all the data micro-ops. While a sequence is in flight the block reports itself not ready, so that issue is held. Address generation and the memory access itself belong to other blocks.

Top module: `lsm_uop_seq`

## Requirements
- R1: After reset `ready_o` is 1, and `uop_valid_o`, `uop_last_o` and `illegal_o` are 0.
- R2: In mode 2'b00 (multi-word) with a legal count N, an accepted request yields its N data micro-ops on N consecutive cycles, the first in the cycle after acceptance; data micro-op k (k = 0..N-1) has register (first + k) mod 32 and offset 4*k.
- R3: When the base-update flag is set in mode 2'b00 or 2'b10, exactly one extra micro-op follows the data micro-ops, with the base register, `uop_base_o`=1, `uop_wr_o`=1, `uop_mm_o`=0 (result at execute) and offset 4*N in mode 2'b00 or 0 in mode 2'b10.
- R4: Data micro-ops of a multi-word load have `uop_wr_o`=1 and `uop_mm_o`=1, and only the final data micro-op has `uop_fwd_o`=1; data micro-ops of a multi-word store have `uop_wr_o`, `uop_mm_o` and `uop_fwd_o` all 0.
- R5: Mode 2'b01 (paired move) yields two writing micro-ops, `uop_mm_o`=0, offset 0: the even register (first with bit 0 cleared) then the odd one (bit 0 set); the count, store and base-update inputs have no effect.
- R6: Mode 2'b10 (store with register offset) yields a non-writing micro-op on the base register followed by a non-writing micro-op on the data register `first`, both offset 0; the count has no effect.
- R7: In mode 2'b00 the legal counts are 1 to 8 and 12; any other count (including 0) produces no micro-op, pulses `illegal_o` for one cycle in the cycle after the request, and leaves `ready_o` at 1.
- R8: Mode 2'b11 is reserved and is rejected the same way as an illegal count.
- R9: `ready_o` is 0 from the cycle after acceptance through the cycle of the last micro-op and 1 in the cycle after it; a request presented while `ready_o` is 0 has no effect on the sequence in flight and is not accepted.
- R10: `uop_last_o` is 1 on exactly one micro-op per accepted legal request, the final one, and `uop_valid_o` stays 1 without gaps from the first micro-op to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Decoded instruction present |
| req_mode_i | input | 2 | Sequence shape: 00 multi-word, 01 paired move, 10 register-offset store, 11 reserved |
| req_store_i | input | 1 | Multi-word direction: 1 store, 0 load |
| req_cnt_i | input | 4 | Register count for multi-word mode |
| req_base_upd_i | input | 1 | Base register writeback requested |
| req_first_reg_i | input | 5 | First data register (pair register for moves) |
| req_base_reg_i | input | 5 | Base address register |
| ready_o | output | 1 | Idle and able to accept a request |
| illegal_o | output | 1 | One-cycle pulse for a rejected request |
| uop_valid_o | output | 1 | Micro-op present this cycle |
| uop_reg_o | output | 5 | Register the micro-op writes or reads |
| uop_off_o | output | 8 | Byte offset from the base address |
| uop_wr_o | output | 1 | Micro-op writes the register file |
| uop_base_o | output | 1 | Micro-op is the base writeback |
| uop_mm_o | output | 1 | Result ready at the memory stage (0: execute) |
| uop_fwd_o | output | 1 | Result is the one forwarded to dependent consumers |
| uop_last_o | output | 1 | Final micro-op of the sequence |

## Verification
The hardest situation to reach from the ports is a request arriving while a sequence is still being emitted, since a correct block simply refuses it and any leak shows up only as a corrupted or lengthened sequence. The bench therefore drives a valid request with changing contents on every cycle of every sequence, then checks that each micro-op still matches the original request and that the block returns to ready exactly one cycle after the last micro-op. The sweep covers every mode, every 4-bit count, both directions, both base-update settings and first registers that make the register number wrap past 31.

// File: rtl/lsm_pkg.sv
`timescale 1ns/1ps
package lsm_pkg;
  typedef enum logic [1:0] {
    MODE_MULTI = 2'b00,
    MODE_PAIR  = 2'b01,
    MODE_STRR  = 2'b10,
    MODE_RSVD  = 2'b11
  } seq_mode_e;
endpackage

// File: rtl/lsm_decode.sv
`timescale 1ns/1ps
module lsm_decode
  import lsm_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int DENSE_MAX = 8,
  parameter int MAX_CNT   = 12,
  parameter int IDX_W     = 4
) (
  input  seq_mode_e          mode_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               base_upd_i,
  output logic               legal_o,
  output logic [IDX_W-1:0]   n_data_o,
  output logic               has_base_o,
  output logic [IDX_W-1:0]   n_total_o
);
  logic cnt_ok;

  assign cnt_ok = ((cnt_i != '0) && (cnt_i <= CNT_W'(DENSE_MAX))) ||
                  (cnt_i == CNT_W'(MAX_CNT));

  always_comb begin
    legal_o    = 1'b0;
    n_data_o   = '0;
    has_base_o = 1'b0;
    unique case (mode_i)
      MODE_MULTI: begin
        legal_o    = cnt_ok;
        n_data_o   = IDX_W'(cnt_i);
        has_base_o = base_upd_i;
      end
      MODE_PAIR: begin
        legal_o  = 1'b1;
        n_data_o = IDX_W'(2);
      end
      MODE_STRR: begin
        legal_o    = 1'b1;
        n_data_o   = IDX_W'(2);
        has_base_o = base_upd_i;
      end
      default: ;
    endcase
  end

  assign n_total_o = n_data_o + IDX_W'(has_base_o);

  // R7
  always_comb begin
    legal_cnt_chk: assert ((mode_i != MODE_MULTI) || !legal_o || (n_data_o != '0));
  end
endmodule

// File: rtl/lsm_step_ctr.sv
`timescale 1ns/1ps
module lsm_step_ctr #(
  parameter int IDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  n_total_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              last_o
);
  logic [IDX_W-1:0] total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      idx_o   <= '0;
      total_q <= '0;
    end else if (start_i && !busy_o) begin
      busy_o  <= 1'b1;
      idx_o   <= '0;
      total_q <= n_total_i;
    end else if (busy_o) begin
      if (last_o) begin
        busy_o <= 1'b0;
        idx_o  <= '0;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end
  end

  assign last_o = busy_o && (idx_o == total_q - 1'b1);

  // R10
  step_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (idx_o < total_q));
  // R10
  no_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o) |=> busy_o);
endmodule

// File: rtl/lsm_uop_gen.sv
`timescale 1ns/1ps
module lsm_uop_gen
  import lsm_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int IDX_W      = 4,
  parameter int OFF_W      = 8,
  parameter int WORD_BYTES = 4
) (
  input  seq_mode_e          mode_i,
  input  logic               store_i,
  input  logic [REG_W-1:0]   first_reg_i,
  input  logic [REG_W-1:0]   base_reg_i,
  input  logic [IDX_W-1:0]   n_data_i,
  input  logic               has_base_i,
  input  logic               active_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [REG_W-1:0]   reg_o,
  output logic [OFF_W-1:0]   off_o,
  output logic               wr_o,
  output logic               base_o,
  output logic               mm_o,
  output logic               fwd_o
);
  localparam logic [OFF_W-1:0] STEP = OFF_W'(WORD_BYTES);

  logic in_base;
  assign in_base = has_base_i && (idx_i == n_data_i);

  always_comb begin
    reg_o  = '0;
    off_o  = '0;
    wr_o   = 1'b0;
    base_o = 1'b0;
    mm_o   = 1'b0;
    fwd_o  = 1'b0;
    if (in_base) begin
      reg_o  = base_reg_i;
      wr_o   = 1'b1;
      base_o = 1'b1;
      off_o  = (mode_i == MODE_MULTI) ? OFF_W'(n_data_i) * STEP : '0;
    end else begin
      unique case (mode_i)
        MODE_MULTI: begin
          reg_o = first_reg_i + REG_W'(idx_i);
          off_o = OFF_W'(idx_i) * STEP;
          wr_o  = !store_i;
          mm_o  = !store_i;
          fwd_o = !store_i && (idx_i == n_data_i - 1'b1);
        end
        MODE_PAIR: begin
          reg_o = {first_reg_i[REG_W-1:1], idx_i[0]};
          wr_o  = 1'b1;
        end
        MODE_STRR: begin
          reg_o = (idx_i == '0) ? base_reg_i : first_reg_i;
        end
        default: ;
      endcase
    end
  end

  // R4
  always_comb begin
    fwd_is_late_chk: assert (!active_i || !fwd_o || (mm_o && wr_o && !base_o));
  end
  // R5
  always_comb begin
    pair_even_first_chk: assert (!active_i || mode_i != MODE_PAIR || idx_i != '0 || reg_o[0] == 1'b0);
  end
  // R3
  always_comb begin
    base_at_ex_chk: assert (!active_i || !base_o || (wr_o && !mm_o));
  end
endmodule

// File: rtl/lsm_uop_seq.sv
`timescale 1ns/1ps
module lsm_uop_seq
  import lsm_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int CNT_W      = 4,
  parameter int OFF_W      = 8,
  parameter int DENSE_MAX  = 8,
  parameter int MAX_CNT    = 12,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_mode_i,
  input  logic              req_store_i,
  input  logic [CNT_W-1:0]  req_cnt_i,
  input  logic              req_base_upd_i,
  input  logic [REG_W-1:0]  req_first_reg_i,
  input  logic [REG_W-1:0]  req_base_reg_i,
  output logic              ready_o,
  output logic              illegal_o,
  output logic              uop_valid_o,
  output logic [REG_W-1:0]  uop_reg_o,
  output logic [OFF_W-1:0]  uop_off_o,
  output logic              uop_wr_o,
  output logic              uop_base_o,
  output logic              uop_mm_o,
  output logic              uop_fwd_o,
  output logic              uop_last_o
);
  localparam int IDX_W = $clog2(MAX_CNT + 2);

  seq_mode_e        dec_mode;
  logic             dec_legal, dec_has_base;
  logic [IDX_W-1:0] dec_n_data, dec_n_total;
  logic             accept, start, busy;
  logic [IDX_W-1:0] idx;

  seq_mode_e        mode_q;
  logic             store_q, has_base_q, illegal_q;
  logic [REG_W-1:0] first_q, base_q;
  logic [IDX_W-1:0] n_data_q;

  assign dec_mode = seq_mode_e'(req_mode_i);

  lsm_decode #(
    .CNT_W(CNT_W), .DENSE_MAX(DENSE_MAX), .MAX_CNT(MAX_CNT), .IDX_W(IDX_W)
  ) u_dec (
    .mode_i(dec_mode), .cnt_i(req_cnt_i), .base_upd_i(req_base_upd_i),
    .legal_o(dec_legal), .n_data_o(dec_n_data), .has_base_o(dec_has_base),
    .n_total_o(dec_n_total)
  );

  assign accept = req_valid_i && !busy;
  assign start  = accept && dec_legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_MULTI;
      store_q    <= 1'b0;
      has_base_q <= 1'b0;
      first_q    <= '0;
      base_q     <= '0;
      n_data_q   <= '0;
      illegal_q  <= 1'b0;
    end else begin
      illegal_q <= accept && !dec_legal;
      if (start) begin
        mode_q     <= dec_mode;
        store_q    <= req_store_i;
        has_base_q <= dec_has_base;
        first_q    <= req_first_reg_i;
        base_q     <= req_base_reg_i;
        n_data_q   <= dec_n_data;
      end
    end
  end

  lsm_step_ctr #(.IDX_W(IDX_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .n_total_i(dec_n_total),
    .busy_o(busy), .idx_o(idx), .last_o(uop_last_o)
  );

  lsm_uop_gen #(
    .REG_W(REG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_BYTES(WORD_BYTES)
  ) u_gen (
    .mode_i(mode_q), .store_i(store_q), .first_reg_i(first_q), .base_reg_i(base_q),
    .n_data_i(n_data_q), .has_base_i(has_base_q), .active_i(busy), .idx_i(idx),
    .reg_o(uop_reg_o), .off_o(uop_off_o), .wr_o(uop_wr_o), .base_o(uop_base_o),
    .mm_o(uop_mm_o), .fwd_o(uop_fwd_o)
  );

  assign uop_valid_o = busy;
  assign ready_o     = !busy;
  assign illegal_o   = illegal_q;

  // R2
  start_emits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o && dec_legal) |=> uop_valid_o);
  // R7
  reject_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!uop_valid_o && ready_o));
  // R10
  last_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_last_o |=> !uop_valid_o);
  // R9
  hold_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && !uop_last_o) |=> ($stable(first_q) && $stable(base_q) && $stable(mode_q)));
endmodule

// File: tb/tb_lsm_uop_seq.sv
`timescale 1ns/1ps
module tb_lsm_uop_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = '0;
  logic       req_store = 1'b0;
  logic [3:0] req_cnt = '0;
  logic       req_bu = 1'b0;
  logic [4:0] req_first = '0;
  logic [4:0] req_base = '0;
  logic       ready, illegal, uv, uwr, ubase, umm, ufwd, ulast;
  logic [4:0] ureg;
  logic [7:0] uoff;

  int n_chk = 0;
  int n_bad = 0;

  int e_n;
  int e_reg[16], e_off[16], e_wr[16], e_base[16], e_mm[16], e_fwd[16];

  always #5 clk = ~clk;

  lsm_uop_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .req_store_i(req_store), .req_cnt_i(req_cnt), .req_base_upd_i(req_bu),
    .req_first_reg_i(req_first), .req_base_reg_i(req_base),
    .ready_o(ready), .illegal_o(illegal), .uop_valid_o(uv), .uop_reg_o(ureg),
    .uop_off_o(uoff), .uop_wr_o(uwr), .uop_base_o(ubase), .uop_mm_o(umm),
    .uop_fwd_o(ufwd), .uop_last_o(ulast)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (mode %0d cnt %0d st %0d bu %0d first %0d)",
               tag, what, act, exp, req_mode, req_cnt, req_store, req_bu, req_first);
    end
  endtask

  task automatic add(int r, int o, int w, int b, int m, int f);
    e_reg[e_n] = r; e_off[e_n] = o; e_wr[e_n] = w;
    e_base[e_n] = b; e_mm[e_n] = m; e_fwd[e_n] = f;
    e_n++;
  endtask

  task automatic plan(int m, int c, int st, int bu, int fr, int br);
    e_n = 0;
    if (m == 0) begin
      if ((c >= 1 && c <= 8) || c == 12) begin
        for (int k = 0; k < c; k++)
          add((fr + k) % 32, 4 * k, st ? 0 : 1, 0, st ? 0 : 1, (!st && k == c - 1) ? 1 : 0);
        if (bu != 0) add(br, 4 * c, 1, 1, 0, 0);
      end
    end else if (m == 1) begin
      add(fr & 30, 0, 1, 0, 0, 0);
      add(fr | 1, 0, 1, 0, 0, 0);
    end else if (m == 2) begin
      add(br, 0, 0, 0, 0, 0);
      add(fr, 0, 0, 0, 0, 0);
      if (bu != 0) add(br, 0, 1, 1, 0, 0);
    end
  endtask

  task automatic run_one(int m, int c, int st, int bu, int fr);
    int br;
    string t;
    br = (fr + 7) % 32;
    plan(m, c, st, bu, fr, br);
    @(negedge clk);
    chk("R9", "ready before request", int'(ready), 1);
    req_valid = 1'b1; req_mode = 2'(m); req_cnt = 4'(c);
    req_store = 1'(st); req_bu = 1'(bu); req_first = 5'(fr); req_base = 5'(br);
    @(negedge clk);
    if (e_n == 0) begin
      req_valid = 1'b0;
      t = (m == 3) ? "R8" : "R7";
      chk(t, "illegal pulse", int'(illegal), 1);
      chk(t, "no uop", int'(uv), 0);
      chk(t, "ready kept", int'(ready), 1);
      @(negedge clk);
      chk(t, "pulse one cycle", int'(illegal), 0);
    end else begin
      for (int k = 0; k < e_n; k++) begin
        // junk request during busy: must not disturb the sequence (R9)
        req_valid = 1'b1; req_mode = 2'((k + m) % 4); req_cnt = 4'(k + 3);
        req_store = 1'(k); req_bu = 1'(~k); req_first = 5'(k * 5); req_base = 5'(k * 3);
        if (e_base[k] != 0) t = "R3";
        else if (m == 1) t = "R5";
        else if (m == 2) t = "R6";
        else t = "R2";
        chk("R10", "valid", int'(uv), 1);
        chk("R9", "busy", int'(ready), 0);
        chk(t, "reg", int'(ureg), e_reg[k]);
        chk(t, "off", int'(uoff), e_off[k]);
        chk((m == 0 && e_base[k] == 0) ? "R4" : t, "wr", int'(uwr), e_wr[k]);
        chk((m == 0 && e_base[k] == 0) ? "R4" : t, "mm", int'(umm), e_mm[k]);
        chk("R4", "fwd", int'(ufwd), e_fwd[k]);
        chk("R3", "base flag", int'(ubase), e_base[k]);
        chk("R10", "last", int'(ulast), (k == e_n - 1) ? 1 : 0);
        @(negedge clk);
      end
      req_valid = 1'b0;
      chk("R10", "idle after last", int'(uv), 0);
      chk("R9", "ready after last", int'(ready), 1);
      chk("R9", "no illegal from junk", int'(illegal), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "reset ready", int'(ready), 1);
    chk("R1", "reset valid", int'(uv), 0);
    chk("R1", "reset last", int'(ulast), 0);
    chk("R1", "reset illegal", int'(illegal), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset ready", int'(ready), 1);
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 16; c++)
        for (int st = 0; st < 2; st++)
          for (int bu = 0; bu < 2; bu++)
            for (int fi = 0; fi < 3; fi++)
              run_one(m, c, st, bu, (fi == 0) ? 0 : (fi == 1) ? 31 : 13);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule